// File: doc/BRIEF.md
# Self-Checking BCD Posting Arithmetic Unit

The unit adds, subtracts or simply stores multi-digit binary-coded-decimal words. It writes the outcome to an external store and proves that the stored value is right before it reports completion. Each decimal digit travels as five bits: the 4-bit value and one redundancy bit that makes the count of ones even. Parity is checked at every place where data leaves a register or arrives from the store.

After an arithmetic result has been written, the unit reads it back. It applies the opposite operation to the value read back, using the same second operand. For a sum it subtracts, and for a difference it adds. The recovered value must match the original first operand. A plain store write is confirmed by reading the word back and comparing it with the item that was meant to be written.

Any failed check stops the operation at once. The error flag and a code naming the check stay up until a clear pulse arrives. A completion pulse is produced only when every check has passed.

Top module: `bcd_post_unit`

## Requirements
- R1: A word holds NDIG digits; digit k sits in bits [5k+3:5k] as a BCD value, and bit 5k+4 is its parity bit, chosen so that the five bits hold an even number of ones. If either latched operand has a digit with odd parity, the unit raises err with err_code 1 (parity), never asserts st_we for that operation, and never pulses done.
- R2: Operation code 0 (add) gives res = (A + B) mod 10^NDIG, and ovf = 1 exactly when A + B >= 10^NDIG.
- R3: Operation code 1 (subtract) gives res = (A - B) mod 10^NDIG, and ovf = 1 exactly when A < B.
- R4: Operation codes 2 and 3 (store write) give res = A and ovf = 0, and opb plays no part in the value.
- R5: Each accepted operation asserts st_we for exactly one cycle, with st_addr equal to the latched address and st_wdata equal to res. Every digit of st_wdata carries correct even parity.
- R6: If the word read back from the store has a digit with odd parity, the unit raises err with err_code 1.
- R7: For add or subtract, if the read-back word passes parity but the opposite operation on it with B does not return A, the unit raises err with err_code 2 (inverse mismatch).
- R8: For a store write, if the read-back word passes parity but differs from A, the unit raises err with err_code 3 (write mismatch).
- R9: Once raised, err and err_code hold their values, and start is ignored, until clr is high on a clock edge. After that edge err is 0, err_code is 0, and a new operation may begin.
- R10: done is a one-cycle pulse, is never high together with err, and appears only for an operation whose checks have all passed.
- R11: While rst is high, done, err, st_we and err_code are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Clears a held error |
| start | input | 1 | Begins an operation while idle |
| op | input | 2 | 0 add, 1 subtract, 2 or 3 store write |
| addr | input | AW | Store location for the result |
| opa | input | NDIG*5 | First operand, digits with parity |
| opb | input | NDIG*5 | Second operand, digits with parity |
| st_we | output | 1 | Store write enable |
| st_addr | output | AW | Store address for write and read-back |
| st_wdata | output | NDIG*5 | Store write data |
| st_rdata | input | NDIG*5 | Store read data, valid one cycle after the address |
| res | output | NDIG*5 | Result word with parity |
| ovf | output | 1 | Carry for add, borrow for subtract |
| done | output | 1 | Operation verified and complete |
| err | output | 1 | A check failed; held until clr |
| err_code | output | 2 | 1 parity, 2 inverse mismatch, 3 write mismatch |

## Verification
In one cycle the read-back word is both parity-checked and fed to the inverse adder, so a corrupted store word could be claimed by either check. The bench corrupts the stored word in two ways. A single flipped value bit must be reported as a parity fault. A value bit flipped together with its parity bit passes parity and must be reported as an inverse mismatch after an arithmetic operation, or as a write mismatch after a store write. The error code seen at the port decides which check won.

// File: rtl/bcdp_pkg.sv
package bcdp_pkg;

    localparam int DIG_W = 5;

    typedef enum logic [2:0] {
        S_IDLE,
        S_COMPUTE,
        S_WRITE,
        S_READBACK,
        S_INVERSE,
        S_COMPARE,
        S_DONE,
        S_ERROR
    } state_t;

    typedef enum logic [1:0] {
        E_NONE    = 2'd0,
        E_PARITY  = 2'd1,
        E_INVERSE = 2'd2,
        E_WRCMP   = 2'd3
    } err_t;

endpackage

// File: rtl/bcdp_digit_add.sv
module bcdp_digit_add (
    input  logic [3:0] a,
    input  logic [3:0] b,
    input  logic       cin,
    output logic [3:0] s,
    output logic       cout
);
    logic [4:0] raw;

    assign raw = {1'b0, a} + {1'b0, b} + {4'b0, cin};

    always_comb begin
        if (raw > 5'd9) begin
            {cout, s} = raw + 5'd6;
        end else begin
            {cout, s} = raw;
        end
    end
endmodule

// File: rtl/bcdp_word_addsub.sv
module bcdp_word_addsub #(
    parameter int NDIG = 4
) (
    input  logic [NDIG*bcdp_pkg::DIG_W-1:0] x,
    input  logic [NDIG*bcdp_pkg::DIG_W-1:0] y,
    input  logic                            sub,
    output logic [NDIG*bcdp_pkg::DIG_W-1:0] z,
    output logic                            carry
);
    localparam int DW = bcdp_pkg::DIG_W;

    logic [NDIG:0] c;
    assign c[0] = sub;

    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        logic [3:0] yd;
        logic [3:0] ym;
        logic [3:0] sd;
        assign yd = y[g*DW +: 4];
        assign ym = sub ? (4'd9 - yd) : yd;
        bcdp_digit_add u_add (
            .a   (x[g*DW +: 4]),
            .b   (ym),
            .cin (c[g]),
            .s   (sd),
            .cout(c[g+1])
        );
        assign z[g*DW +: DW] = {^sd, sd};
    end

    assign carry = c[NDIG];
endmodule

// File: rtl/bcdp_par_check.sv
module bcdp_par_check #(
    parameter int NDIG = 4
) (
    input  logic [NDIG*bcdp_pkg::DIG_W-1:0] word,
    output logic                            bad
);
    localparam int DW = bcdp_pkg::DIG_W;

    logic [NDIG-1:0] per;

    for (genvar g = 0; g < NDIG; g++) begin : g_par
        assign per[g] = ^word[g*DW +: DW];
    end

    assign bad = |per;
endmodule

// File: rtl/bcd_post_unit.sv
module bcd_post_unit #(
    parameter int NDIG = 4,
    parameter int AW   = 4
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            clr,
    input  logic                            start,
    input  logic [1:0]                      op,
    input  logic [AW-1:0]                   addr,
    input  logic [NDIG*bcdp_pkg::DIG_W-1:0] opa,
    input  logic [NDIG*bcdp_pkg::DIG_W-1:0] opb,
    output logic                            st_we,
    output logic [AW-1:0]                   st_addr,
    output logic [NDIG*bcdp_pkg::DIG_W-1:0] st_wdata,
    input  logic [NDIG*bcdp_pkg::DIG_W-1:0] st_rdata,
    output logic [NDIG*bcdp_pkg::DIG_W-1:0] res,
    output logic                            ovf,
    output logic                            done,
    output logic                            err,
    output logic [1:0]                      err_code
);
    import bcdp_pkg::*;

    localparam int W = NDIG * DIG_W;

    state_t         state;
    err_t           code_q;
    logic [1:0]     op_q;
    logic [AW-1:0]  addr_q;
    logic [W-1:0]   a_q, b_q, res_q, rb_q, inv_q;
    logic           ovf_q;

    logic           is_mv, is_sub;
    logic [W-1:0]   fwd_z, inv_z;
    logic           fwd_c, inv_c;
    logic           bad_a, bad_b, bad_r, bad_s;

    assign is_mv  = op_q[1];
    assign is_sub = (op_q == 2'b01);

    bcdp_word_addsub #(.NDIG(NDIG)) u_fwd (
        .x(a_q), .y(b_q), .sub(is_sub), .z(fwd_z), .carry(fwd_c)
    );

    bcdp_word_addsub #(.NDIG(NDIG)) u_inv (
        .x(st_rdata), .y(b_q), .sub(!is_sub), .z(inv_z), .carry(inv_c)
    );

    bcdp_par_check #(.NDIG(NDIG)) u_pa (.word(a_q),      .bad(bad_a));
    bcdp_par_check #(.NDIG(NDIG)) u_pb (.word(b_q),      .bad(bad_b));
    bcdp_par_check #(.NDIG(NDIG)) u_pr (.word(res_q),    .bad(bad_r));
    bcdp_par_check #(.NDIG(NDIG)) u_ps (.word(st_rdata), .bad(bad_s));

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            code_q <= E_NONE;
            op_q   <= '0;
            addr_q <= '0;
            a_q    <= '0;
            b_q    <= '0;
            res_q  <= '0;
            rb_q   <= '0;
            inv_q  <= '0;
            ovf_q  <= 1'b0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (start) begin
                        op_q   <= op;
                        addr_q <= addr;
                        a_q    <= opa;
                        b_q    <= opb;
                        state  <= S_COMPUTE;
                    end
                end
                S_COMPUTE: begin
                    if (bad_a || bad_b) begin
                        code_q <= E_PARITY;
                        state  <= S_ERROR;
                    end else begin
                        res_q  <= is_mv ? a_q : fwd_z;
                        ovf_q  <= is_mv ? 1'b0 : (is_sub ? !fwd_c : fwd_c);
                        state  <= S_WRITE;
                    end
                end
                S_WRITE: begin
                    if (bad_r) begin
                        code_q <= E_PARITY;
                        state  <= S_ERROR;
                    end else begin
                        state  <= S_READBACK;
                    end
                end
                S_READBACK: state <= S_INVERSE;
                S_INVERSE: begin
                    if (bad_s) begin
                        code_q <= E_PARITY;
                        state  <= S_ERROR;
                    end else begin
                        rb_q   <= st_rdata;
                        inv_q  <= inv_z;
                        state  <= S_COMPARE;
                    end
                end
                S_COMPARE: begin
                    if (is_mv && (rb_q != a_q)) begin
                        code_q <= E_WRCMP;
                        state  <= S_ERROR;
                    end else if (!is_mv && (inv_q != a_q)) begin
                        code_q <= E_INVERSE;
                        state  <= S_ERROR;
                    end else begin
                        state  <= S_DONE;
                    end
                end
                S_DONE: state <= S_IDLE;
                S_ERROR: begin
                    if (clr) begin
                        code_q <= E_NONE;
                        state  <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign st_we    = (state == S_WRITE) && !bad_r;
    assign st_addr  = addr_q;
    assign st_wdata = res_q;
    assign res      = res_q;
    assign ovf      = ovf_q;
    assign done     = (state == S_DONE);
    assign err      = (state == S_ERROR);
    assign err_code = code_q;

    logic unused_c;
    assign unused_c = inv_c;
endmodule

// File: rtl/bcd_post_chk.sv
module bcd_post_chk #(
    parameter int NDIG = 4,
    parameter int AW   = 4
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            clr,
    input logic                            st_we,
    input logic [AW-1:0]                   st_addr,
    input logic [AW-1:0]                   addr_q,
    input logic [NDIG*bcdp_pkg::DIG_W-1:0] st_wdata,
    input logic [NDIG*bcdp_pkg::DIG_W-1:0] st_rdata,
    input logic [NDIG*bcdp_pkg::DIG_W-1:0] a_q,
    input logic [NDIG*bcdp_pkg::DIG_W-1:0] b_q,
    input logic                            done,
    input logic                            err,
    input logic [1:0]                      err_code,
    input bcdp_pkg::state_t                state
);
    import bcdp_pkg::*;

    localparam int W = NDIG * DIG_W;

    function automatic logic word_bad(input logic [W-1:0] w);
        logic b;
        b = 1'b0;
        for (int k = 0; k < NDIG; k++) begin
            b = b | (^w[k*DIG_W +: DIG_W]);
        end
        return b;
    endfunction

    AST_OPERAND_PARITY: assert property (@(posedge clk) disable iff (rst)
        (state == S_COMPUTE && (word_bad(a_q) || word_bad(b_q))) |=> (err && err_code == 2'd1)); // R1
    AST_NO_WRITE_BAD_OPERAND: assert property (@(posedge clk) disable iff (rst)
        (state == S_COMPUTE && (word_bad(a_q) || word_bad(b_q))) |=> !st_we); // R1
    AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (rst)
        st_we |=> !st_we); // R5
    AST_WRITE_PARITY: assert property (@(posedge clk) disable iff (rst)
        st_we |-> (!word_bad(st_wdata) && st_addr == addr_q)); // R5
    AST_READBACK_PARITY: assert property (@(posedge clk) disable iff (rst)
        (state == S_INVERSE && word_bad(st_rdata)) |=> (err && err_code == 2'd1)); // R6
    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (err && !clr) |=> (err && $stable(err_code))); // R9
    AST_CODE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !err |-> (err_code == 2'd0)); // R9
    AST_DONE_NOT_ERR: assert property (@(posedge clk) disable iff (rst)
        !(done && err)); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10
    AST_DONE_AFTER_COMPARE: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(state) == S_COMPARE)); // R10
endmodule

bind bcd_post_unit bcd_post_chk #(.NDIG(NDIG), .AW(AW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .st_we   (st_we),
    .st_addr (st_addr),
    .addr_q  (addr_q),
    .st_wdata(st_wdata),
    .st_rdata(st_rdata),
    .a_q     (a_q),
    .b_q     (b_q),
    .done    (done),
    .err     (err),
    .err_code(err_code),
    .state   (state)
);

// File: tb/bcd_post_unit_test.sv
module bcd_post_unit_test;
    localparam int NDIG = 4;
    localparam int AW   = 4;
    localparam int W    = NDIG * 5;
    localparam int MODV = 10000;
    localparam time CLK_PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst, clr, start;
    logic [1:0]    op;
    logic [AW-1:0] addr;
    logic [W-1:0]  opa, opb;
    logic          st_we;
    logic [AW-1:0] st_addr;
    logic [W-1:0]  st_wdata, st_rdata;
    logic [W-1:0]  res;
    logic          ovf, done, err;
    logic [1:0]    err_code;

    logic [W-1:0]  mem [0:(1<<AW)-1];
    logic [W-1:0]  inj;

    int nchk  = 0;
    int nfail = 0;
    bit ended = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_post_unit #(.NDIG(NDIG), .AW(AW)) uut (
        .clk(clk), .rst(rst), .clr(clr), .start(start), .op(op), .addr(addr),
        .opa(opa), .opb(opb), .st_we(st_we), .st_addr(st_addr),
        .st_wdata(st_wdata), .st_rdata(st_rdata), .res(res), .ovf(ovf),
        .done(done), .err(err), .err_code(err_code)
    );

    always @(posedge clk) begin
        if (st_we) mem[st_addr] <= st_wdata ^ inj;
        st_rdata <= mem[st_addr];
    end

    function automatic logic [W-1:0] enc(input int v);
        logic [W-1:0] w;
        logic [3:0]   d;
        int           t;
        t = v;
        w = '0;
        for (int k = 0; k < NDIG; k++) begin
            d = 4'(t % 10);
            t = t / 10;
            w[k*5 +: 5] = {^d, d};
        end
        return w;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    task automatic run_op(input logic [1:0] o, input int a, input int b,
                          input logic [AW-1:0] ad, input logic [W-1:0] amask,
                          input logic [W-1:0] smask, input int ecode, input string req);
        int  nwr;
        bit  gotd, gote;
        int  expv;
        bit  expo;
        nwr = 0; gotd = 0; gote = 0;
        @(negedge clk);
        op = o; opa = enc(a) ^ amask; opb = enc(b); addr = ad; inj = smask; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (st_we) nwr++;
            if (done) begin gotd = 1; break; end
            if (err)  begin gote = 1; break; end
            @(negedge clk);
        end
        if (o[1]) begin
            expv = a; expo = 0;
        end else if (o == 2'd1) begin
            expv = (a - b + MODV) % MODV; expo = (a < b);
        end else begin
            expv = (a + b) % MODV; expo = ((a + b) >= MODV);
        end
        if (ecode == 0) begin
            chk(gotd && !gote, {req, " done"}, {gote, gotd}, 2'b01);
            chk(res == enc(expv), {req, " res"}, res, enc(expv));
            chk(ovf == expo, {req, " ovf"}, ovf, expo);
            chk(mem[ad] == enc(expv), "R5 stored word", mem[ad], enc(expv));
            chk(nwr == 1, "R5 write count", nwr, 1);
        end else begin
            chk(gote && !gotd, {req, " err"}, {gote, gotd}, 2'b10);
            chk(err_code == 2'(ecode), {req, " code"}, err_code, ecode);
            if (amask != '0) chk(nwr == 0, "R1 no write", nwr, 0);
            inj = '0;
            @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (3) begin
                if (st_we) nwr++;
                @(negedge clk);
            end
            chk(err && err_code == 2'(ecode), "R9 hold", {err, err_code}, {1'b1, 2'(ecode)});
            clr = 1'b1;
            @(negedge clk);
            clr = 1'b0;
            chk(!err && err_code == 2'd0, "R9 clear", {err, err_code}, 3'b000);
        end
        inj = '0;
    endtask

    initial begin
        rst = 1'b1; clr = 1'b0; start = 1'b0; op = '0; addr = '0;
        opa = '0; opb = '0; inj = '0;
        void'($urandom(32'd17));
        repeat (3) @(negedge clk);
        chk(!done && !err && !st_we && err_code == 2'd0, "R11 reset",
            {done, err, st_we, err_code}, 0);
        rst = 1'b0;

        run_op(2'd0, 9999, 1, 4'd1, '0, '0, 0, "R2 add carry");
        run_op(2'd0, 0, 0, 4'd2, '0, '0, 0, "R2 add zero");
        run_op(2'd0, 1234, 5678, 4'd3, '0, '0, 0, "R2 add mid");
        run_op(2'd1, 0, 1, 4'd4, '0, '0, 0, "R3 sub borrow");
        run_op(2'd1, 9999, 9999, 4'd5, '0, '0, 0, "R3 sub equal");
        run_op(2'd1, 5000, 1, 4'd6, '0, '0, 0, "R3 sub chain");
        run_op(2'd2, 4321, 9876, 4'd7, '0, '0, 0, "R4 write");
        run_op(2'd3, 90, 0, 4'd8, '0, '0, 0, "R4 write op3");

        run_op(2'd0, 1111, 2222, 4'd9, 20'h00010, '0, 1, "R1 opa parity");
        run_op(2'd1, 3456, 123, 4'd10, '0, 20'h00001, 1, "R6 readback parity");
        run_op(2'd0, 2468, 1357, 4'd11, '0, 20'h00220, 2, "R7 inverse add");
        run_op(2'd1, 8000, 4321, 4'd12, '0, 20'h00220, 2, "R7 inverse sub");
        run_op(2'd2, 7777, 0, 4'd13, '0, 20'h00220, 3, "R8 write compare");
        run_op(2'd2, 7777, 0, 4'd14, '0, 20'h04000, 1, "R6 write parity");
        run_op(2'd0, 10, 20, 4'd15, '0, '0, 0, "R10 after clear");

        for (int n = 0; n < 40; n++) begin
            logic [1:0] ro;
            ro = 2'($urandom % 4);
            run_op(ro, int'($urandom % MODV), int'($urandom % MODV),
                   AW'($urandom), '0, '0, 0,
                   ro[1] ? "R4 random" : (ro[0] ? "R3 random" : "R2 random"));
        end

        finish_run();
    end
endmodule